// File: doc/BRIEF.md
# Periodic Masked Register Copy Engine

This block is a bus master that moves bit-fields from one register to another on a simple internal register bus, at a rate set by software. It holds 48 copy descriptors, a 48-bit enable mask and a period value counted in servo-cycle ticks. Each time the period runs out, the engine makes one pass over the enabled descriptors. For each descriptor it reads the source register and extracts the coded part of it. It then reads the destination register, puts the extracted value into the coded part of that word, and writes the word back.

Configuration arrives through a write-only port that selects a descriptor slot, the mask or the period. Descriptor and mask values are captured in a working copy at the start of each pass. A pass is therefore never affected by writes made while it runs. A zero period stops all copying. A descriptor with an unknown part code, and a trigger that lands while a pass is still running, each set a sticky error flag.

Top module: `fcopy_engine`

## Requirements
- R1: A descriptor is 48 bits: bits [47:40] source part code, [39:24] source address, [23:16] destination part code, [15:0] destination address. Each descriptor that runs performs exactly one source read, then one destination read, then one destination write to the destination address.
- R2: Part codes: 0x00 selects bits [23:0], 0x01 bits [7:0], 0x02 bits [15:8], 0x03 bits [23:16], 0x10 bits [15:0]. The source part is right-aligned and truncated to the width of the destination part. It is then placed at the destination part's position. Destination bits outside that part are written back unchanged.
- R3: Mask bit n enables descriptor n. When the bit is clear, the descriptor makes no bus access and its destination is untouched.
- R4: With period P > 0, a pass is triggered on the first tick after the counter has reached zero, and then on every P-th tick after that. With period 0, no pass is triggered and the bus stays idle.
- R5: Within a pass, enabled descriptors run in ascending index order, each finishing before the next starts. A later descriptor therefore sees values written by an earlier one.
- R6: An enabled descriptor whose source or destination code is not one of the codes in R2 makes no bus access and sets `err_code`. The flag stays set until reset.
- R7: A trigger that arrives while a pass is running sets `err_overrun`, which stays set until reset. The new pass is dropped, not queued.
- R8: Descriptor and mask writes made during a pass do not change that pass. They apply from the next pass on.
- R9: After reset: `busy`, `bus_req`, `err_code` and `err_overrun` are 0, all descriptors and the mask are 0, and the period is 0.
- R10: Once `bus_req` is raised, it stays high with stable `bus_addr`, `bus_wr` and `bus_wdata` until the cycle in which `bus_ack` is high. Read data is taken from `bus_rdata` in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Target of the write: 0 descriptor, 1 mask, 2 period |
| cfg_idx | input | 6 | Descriptor slot for a descriptor write |
| cfg_wdata | input | 48 | Descriptor, mask, or period (low 16 bits) |
| tick | input | 1 | One-cycle servo-cycle tick |
| bus_req | output | 1 | Bus access request |
| bus_wr | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 16 | Register address |
| bus_wdata | output | 24 | Write data |
| bus_rdata | input | 24 | Read data, valid while `bus_ack` is high |
| bus_ack | input | 1 | Access completes in this cycle |
| busy | output | 1 | A pass is in progress |
| err_code | output | 1 | Sticky: unknown part code seen |
| err_overrun | output | 1 | Sticky: trigger dropped during a pass |

## Verification
A wrong part decode or a wrong merge shows up in the data of the very next destination write. So does a stale field register. A broken index walk shows up as a write to an unexpected address or as a write out of order. The scoreboard catches this on that same access. Faults in the period counter or in the snapshot logic show up more slowly: as a wrong number of writes across a run of ticks, or as new configuration leaking into the pass in flight. Those faults appear only once that pass or the following one has drained.

// File: rtl/fcopy_pkg.sv
// Package: shared widths, part-code decode and walker states for the
// periodic field copy engine. Assumes a 24-bit register data path.
package fcopy_pkg;

    localparam int DATA_W = 24;
    localparam int CODE_W = 8;
    localparam int ADDR_W = 16;
    localparam int DESC_W = 2 * (CODE_W + ADDR_W);
    localparam int LSB_W  = $clog2(DATA_W);

    localparam logic [1:0] SEL_DESC   = 2'd0;
    localparam logic [1:0] SEL_MASK   = 2'd1;
    localparam logic [1:0] SEL_PERIOD = 2'd2;

    typedef struct packed {
        logic              ok;
        logic [LSB_W-1:0]  lsb;
        logic [DATA_W-1:0] mask;
    } part_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCAN,
        ST_RD_SRC,
        ST_RD_DST,
        ST_WR_DST
    } walk_st_t;

    // Translate a part code into field position and right-aligned mask.
    function automatic part_t decode_part(input logic [CODE_W-1:0] code);
        part_t p;
        p.ok   = 1'b1;
        p.lsb  = '0;
        p.mask = '0;
        case (code)
            8'h00: p.mask = {DATA_W{1'b1}};
            8'h01: p.mask = DATA_W'(8'hFF);
            8'h02: begin p.mask = DATA_W'(8'hFF); p.lsb = LSB_W'(8);  end
            8'h03: begin p.mask = DATA_W'(8'hFF); p.lsb = LSB_W'(16); end
            8'h10: p.mask = DATA_W'(16'hFFFF);
            default: p.ok = 1'b0;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/fcopy_tick_timer.sv
// Tick timer: holds the period register and a down-counter advanced by tick.
// Fires a pass trigger when the counter is at one or zero on a tick and
// reloads it from the period. Assumes tick is a single-cycle pulse.
module fcopy_tick_timer #(
    parameter int PER_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             per_we,
    input  logic [PER_W-1:0] per_wdata,
    input  logic             tick,
    input  logic             busy,
    output logic [PER_W-1:0] period_q,
    output logic             start,
    output logic             overrun_evt
);

    logic [PER_W-1:0] cnt_q;
    logic             due;

    // Period register: software-written pacing value.
    always_ff @(posedge clk) begin
        if (!rst_n)      period_q <= '0;
        else if (per_we) period_q <= per_wdata;
    end

    assign due = tick && (period_q != '0) && (cnt_q <= PER_W'(1));

    // Down-counter: reload at a trigger, clear while pacing is disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick) begin
            if (period_q == '0)         cnt_q <= '0;
            else if (cnt_q <= PER_W'(1)) cnt_q <= period_q;
            else                         cnt_q <= cnt_q - PER_W'(1);
        end
    end

    assign start       = due && !busy;
    assign overrun_evt = due && busy;

endmodule

// File: rtl/fcopy_desc_bank.sv
// Descriptor bank: software-visible shadow table and mask, plus a working
// copy captured on snap. The walker reads only the working copy, so a pass
// never sees writes made after it started.
module fcopy_desc_bank #(
    parameter int NUM_DESC = 48,
    parameter int DESC_W   = 48,
    localparam int IDX_W   = $clog2(NUM_DESC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              desc_we,
    input  logic              mask_we,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DESC_W-1:0] wr_data,
    input  logic              snap,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DESC_W-1:0] rd_desc,
    output logic              rd_en
);

    logic [DESC_W-1:0]   shadow_q [NUM_DESC];
    logic [DESC_W-1:0]   work_q   [NUM_DESC];
    logic [NUM_DESC-1:0] mask_sh_q;
    logic [NUM_DESC-1:0] mask_wk_q;

    for (genvar g = 0; g < NUM_DESC; g++) begin : g_slot
        // One slot: accept software writes, copy to working set on snap.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                shadow_q[g] <= '0;
                work_q[g]   <= '0;
            end else begin
                if (desc_we && wr_idx == IDX_W'(g)) shadow_q[g] <= wr_data;
                if (snap)                           work_q[g]   <= shadow_q[g];
            end
        end
    end

    // Enable mask: shadow written by software, working copy taken on snap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_sh_q <= '0;
            mask_wk_q <= '0;
        end else begin
            if (mask_we) mask_sh_q <= NUM_DESC'(wr_data);
            if (snap)    mask_wk_q <= mask_sh_q;
        end
    end

    assign rd_desc = work_q[rd_idx];
    assign rd_en   = mask_wk_q[rd_idx];

endmodule

// File: rtl/fcopy_field_merge.sv
// Field merge: combinational extract of the source part and insertion of a
// held field into a destination word. Bits outside the destination part
// pass through unchanged.
module fcopy_field_merge
    import fcopy_pkg::*;
(
    input  logic [CODE_W-1:0] src_code,
    input  logic [CODE_W-1:0] dst_code,
    input  logic [DATA_W-1:0] src_word,
    input  logic [DATA_W-1:0] dst_word,
    input  logic [DATA_W-1:0] held_field,
    output logic              codes_ok,
    output logic [DATA_W-1:0] field_out,
    output logic [DATA_W-1:0] merged
);

    part_t sp;
    part_t dp;

    // Decode both part codes and form the extract and merge results.
    always_comb begin
        sp        = decode_part(src_code);
        dp        = decode_part(dst_code);
        codes_ok  = sp.ok && dp.ok;
        field_out = (src_word >> sp.lsb) & sp.mask;
        merged    = (dst_word & ~(dp.mask << dp.lsb))
                  | ((held_field & dp.mask) << dp.lsb);
    end

endmodule

// File: rtl/fcopy_walker.sv
// Walker: steps through descriptor indices in ascending order, one per scan
// cycle. For each enabled descriptor with valid codes it runs the read,
// read, write sequence on the bus. Assumes the bus slave holds bus_ack high
// for one cycle per access.
module fcopy_walker
    import fcopy_pkg::*;
#(
    parameter int NUM_DESC = 48,
    localparam int IDX_W   = $clog2(NUM_DESC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DESC_W-1:0] desc,
    input  logic              desc_en,
    input  logic              codes_ok,
    input  logic [DATA_W-1:0] field_out,
    input  logic [DATA_W-1:0] merged,
    input  logic              bus_ack,
    output logic [IDX_W-1:0]  idx,
    output logic [DATA_W-1:0] held_field,
    output logic              busy,
    output logic              code_evt,
    output logic              bus_req,
    output logic              bus_wr,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata
);

    walk_st_t          st_q;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] field_q;
    logic [DATA_W-1:0] wdata_q;
    logic [ADDR_W-1:0] src_addr;
    logic [ADDR_W-1:0] dst_addr;
    logic              last;

    assign src_addr = desc[DESC_W-CODE_W-1 -: ADDR_W];
    assign dst_addr = desc[ADDR_W-1:0];
    assign last     = (idx_q == IDX_W'(NUM_DESC - 1));

    // Sequencer: idle, scan an index, then three bus accesses per copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            idx_q   <= '0;
            field_q <= '0;
            wdata_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        idx_q <= '0;
                        st_q  <= ST_SCAN;
                    end
                end
                ST_SCAN: begin
                    if (desc_en && codes_ok) begin
                        st_q <= ST_RD_SRC;
                    end else if (last) begin
                        st_q <= ST_IDLE;
                    end else begin
                        idx_q <= idx_q + IDX_W'(1);
                    end
                end
                ST_RD_SRC: begin
                    if (bus_ack) begin
                        field_q <= field_out;
                        st_q    <= ST_RD_DST;
                    end
                end
                ST_RD_DST: begin
                    if (bus_ack) begin
                        wdata_q <= merged;
                        st_q    <= ST_WR_DST;
                    end
                end
                ST_WR_DST: begin
                    if (bus_ack) begin
                        if (last) begin
                            st_q <= ST_IDLE;
                        end else begin
                            idx_q <= idx_q + IDX_W'(1);
                            st_q  <= ST_SCAN;
                        end
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Bus drive and status derived from the current state.
    always_comb begin
        bus_req   = (st_q == ST_RD_SRC) || (st_q == ST_RD_DST) || (st_q == ST_WR_DST);
        bus_wr    = (st_q == ST_WR_DST);
        bus_addr  = (st_q == ST_RD_SRC) ? src_addr : dst_addr;
        bus_wdata = wdata_q;
        busy      = (st_q != ST_IDLE);
        code_evt  = (st_q == ST_SCAN) && desc_en && !codes_ok;
    end

    assign idx        = idx_q;
    assign held_field = field_q;

endmodule

// File: rtl/fcopy_engine.sv
// Top: periodic masked register copy engine. Wires the tick timer, the
// descriptor bank, the field merge and the walker, and keeps the two sticky
// error flags. Assumes it is the only master on its register bus.
module fcopy_engine
    import fcopy_pkg::*;
#(
    parameter int NUM_DESC = 48,
    parameter int PER_W    = 16,
    localparam int IDX_W   = $clog2(NUM_DESC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [DESC_W-1:0] cfg_wdata,
    input  logic              tick,
    output logic              bus_req,
    output logic              bus_wr,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ack,
    output logic              busy,
    output logic              err_code,
    output logic              err_overrun
);

    logic [PER_W-1:0]  period_q;
    logic              start;
    logic              overrun_evt;
    logic              code_evt;
    logic [IDX_W-1:0]  idx;
    logic [DESC_W-1:0] desc;
    logic              desc_en;
    logic              codes_ok;
    logic [DATA_W-1:0] field_out;
    logic [DATA_W-1:0] merged;
    logic [DATA_W-1:0] held_field;

    fcopy_tick_timer #(.PER_W(PER_W)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .per_we      (cfg_we && cfg_sel == SEL_PERIOD),
        .per_wdata   (cfg_wdata[PER_W-1:0]),
        .tick        (tick),
        .busy        (busy),
        .period_q    (period_q),
        .start       (start),
        .overrun_evt (overrun_evt)
    );

    fcopy_desc_bank #(.NUM_DESC(NUM_DESC), .DESC_W(DESC_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .desc_we (cfg_we && cfg_sel == SEL_DESC),
        .mask_we (cfg_we && cfg_sel == SEL_MASK),
        .wr_idx  (cfg_idx),
        .wr_data (cfg_wdata),
        .snap    (start),
        .rd_idx  (idx),
        .rd_desc (desc),
        .rd_en   (desc_en)
    );

    fcopy_field_merge u_merge (
        .src_code   (desc[DESC_W-1 -: CODE_W]),
        .dst_code   (desc[ADDR_W+CODE_W-1 -: CODE_W]),
        .src_word   (bus_rdata),
        .dst_word   (bus_rdata),
        .held_field (held_field),
        .codes_ok   (codes_ok),
        .field_out  (field_out),
        .merged     (merged)
    );

    fcopy_walker #(.NUM_DESC(NUM_DESC)) u_walk (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .desc       (desc),
        .desc_en    (desc_en),
        .codes_ok   (codes_ok),
        .field_out  (field_out),
        .merged     (merged),
        .bus_ack    (bus_ack),
        .idx        (idx),
        .held_field (held_field),
        .busy       (busy),
        .code_evt   (code_evt),
        .bus_req    (bus_req),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata)
    );

    // Sticky error flags: set by events, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_code    <= 1'b0;
            err_overrun <= 1'b0;
        end else begin
            if (code_evt)    err_code    <= 1'b1;
            if (overrun_evt) err_overrun <= 1'b1;
        end
    end

endmodule

// File: rtl/fcopy_engine_chk.sv
// Checker for fcopy_engine: bus hold rules, idle quietness, sticky flags
// and the zero-period stop. Attached by the bind below.
module fcopy_engine_chk
    import fcopy_pkg::*;
#(
    parameter int PER_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic              bus_ack,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              busy,
    input logic              err_code,
    input logic              err_overrun,
    input logic [PER_W-1:0]  period_q
);

    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_wr) && $stable(bus_wdata)));

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_req);

    assert_code_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err_code |=> err_code);

    assert_overrun_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err_overrun |=> err_overrun);

    assert_zero_period_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (period_q == '0 && !busy) |=> !busy);

endmodule

bind fcopy_engine fcopy_engine_chk #(.PER_W(PER_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_req     (bus_req),
    .bus_ack     (bus_ack),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .busy        (busy),
    .err_code    (err_code),
    .err_overrun (err_overrun),
    .period_q    (period_q)
);

// File: tb/fcopy_engine_tb.sv
// Scoreboard bench: expect_pass() pushes predicted writes, the monitor pops
// and compares them as the engine writes.
module fcopy_engine_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [5:0]  cfg_idx = '0;
    logic [47:0] cfg_wdata = '0;
    logic        tick = 1'b0;
    logic        bus_req, bus_wr, bus_ack, busy, err_code, err_overrun;
    logic [15:0] bus_addr;
    logic [23:0] bus_wdata, bus_rdata;

    int n_checks = 0;
    int n_errors = 0;
    int n_writes = 0;
    int n_req_cyc = 0;
    int touch25 = 0;
    int touch26 = 0;
    int hold_viol = 0;

    logic [23:0] mem     [256];
    logic [23:0] ref_mem [256];
    logic [47:0] desc_m  [48];
    logic [47:0] mask_m;
    logic [39:0] expq[$];
    logic        slow = 1'b0;
    int          wcnt = 0;
    logic        p_req = 1'b0, p_ack = 1'b0, p_wr = 1'b0;
    logic [15:0] p_addr = '0;

    always #5 clk = ~clk;

    fcopy_engine u_dut (.*);

    // Bus slave: acknowledges after one or two wait cycles, alternating.
    always @(posedge clk) begin
        if (!rst_n || !bus_req || bus_ack) begin
            bus_ack <= 1'b0;
            wcnt    <= 0;
            if (bus_ack) slow <= ~slow;
        end else if (wcnt >= (slow ? 1 : 0)) begin
            bus_ack <= 1'b1;
        end else begin
            wcnt <= wcnt + 1;
        end
        if (bus_req && bus_ack && bus_wr) mem[bus_addr[7:0]] <= bus_wdata;
    end
    assign bus_rdata = mem[bus_addr[7:0]];

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Monitor: compare every completed write against the scoreboard queue.
    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_req) n_req_cyc++;
            if (p_req && !p_ack && (!bus_req || bus_addr != p_addr || bus_wr != p_wr))
                hold_viol++;
            if (bus_req && bus_ack) begin
                if (bus_addr[7:0] == 8'h25) touch25++;
                if (bus_addr[7:0] == 8'h26) touch26++;
            end
            if (bus_req && bus_ack && bus_wr) begin
                n_writes++;
                if (expq.size() == 0) begin
                    check(1'b0, "R1", "unexpected write", {bus_addr, bus_wdata}, 0);
                end else begin
                    logic [39:0] e;
                    e = expq.pop_front();
                    check({bus_addr, bus_wdata} == e, "R2/R5", "write addr+data",
                          {bus_addr, bus_wdata}, e);
                end
            end
            p_req = bus_req; p_ack = bus_ack; p_wr = bus_wr; p_addr = bus_addr;
        end
    end

    function automatic logic [23:0] get_part(input logic [7:0] c, input logic [23:0] w,
                                             output bit ok);
        ok = 1'b1;
        case (c)
            8'h00: return w;
            8'h01: return {16'h0, w[7:0]};
            8'h02: return {16'h0, w[15:8]};
            8'h03: return {16'h0, w[23:16]};
            8'h10: return {8'h0, w[15:0]};
            default: begin ok = 1'b0; return '0; end
        endcase
    endfunction

    function automatic logic [23:0] put_part(input logic [7:0] c, input logic [23:0] w,
                                             input logic [23:0] v);
        case (c)
            8'h00: return v;
            8'h01: return {w[23:8], v[7:0]};
            8'h02: return {w[23:16], v[7:0], w[7:0]};
            8'h03: return {v[7:0], w[15:0]};
            default: return {w[23:16], v[15:0]};
        endcase
    endfunction

    // Driver: predict one pass from the bench model and queue the writes.
    task automatic expect_pass();
        for (int i = 0; i < 48; i++) begin
            if (mask_m[i]) begin
                bit ok_s, ok_d;
                logic [23:0] v, nw;
                logic [47:0] d;
                d = desc_m[i];
                v = get_part(d[47:40], ref_mem[d[31:24]], ok_s);
                void'(get_part(d[23:16], 24'h0, ok_d));
                if (ok_s && ok_d) begin
                    nw = put_part(d[23:16], ref_mem[d[7:0]], v);
                    ref_mem[d[7:0]] = nw;
                    expq.push_back({d[15:0], nw});
                end
            end
        end
    endtask

    task automatic cfg_write(input logic [1:0] sel, input int idx, input logic [47:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_idx = 6'(idx); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (sel == 2'd0) desc_m[idx] = d;
        if (sel == 2'd1) mask_m = d;
    endtask

    task automatic pulse_tick();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    function automatic logic [47:0] mk(input logic [7:0] sc, input logic [15:0] sa,
                                       input logic [7:0] dc, input logic [15:0] da);
        return {sc, sa, dc, da};
    endfunction

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        int w0, r0;
        for (int i = 0; i < 256; i++) begin
            mem[i]     = {8'(i) ^ 8'h5A, ~8'(i), 8'(i) + 8'h31};
            ref_mem[i] = mem[i];
        end
        for (int i = 0; i < 48; i++) desc_m[i] = '0;
        mask_m = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy, "R9", "busy after reset", busy, 0);
        check(!bus_req, "R9", "bus_req after reset", bus_req, 0);
        check(!err_code, "R9", "err_code after reset", err_code, 0);
        check(!err_overrun, "R9", "err_overrun after reset", err_overrun, 0);
        pulse_tick();
        check(n_req_cyc == 0, "R9", "no pass with reset period", n_req_cyc, 0);

        // Pass 1: codes, ordering (D4 reads D3's result), last slot, masked D5.
        cfg_write(2'd0, 0,  mk(8'h00, 16'h0110, 8'h00, 16'h0120));
        cfg_write(2'd0, 1,  mk(8'h01, 16'h0111, 8'h03, 16'h0121));
        cfg_write(2'd0, 2,  mk(8'h03, 16'h0112, 8'h02, 16'h0122));
        cfg_write(2'd0, 3,  mk(8'h10, 16'h0113, 8'h01, 16'h0123));
        cfg_write(2'd0, 4,  mk(8'h02, 16'h0123, 8'h10, 16'h0124));
        cfg_write(2'd0, 5,  mk(8'h00, 16'h0115, 8'h00, 16'h0125));
        cfg_write(2'd0, 47, mk(8'h00, 16'h0130, 8'h10, 16'h0131));
        cfg_write(2'd1, 0, 48'h8000_0000_001F);
        cfg_write(2'd2, 0, 48'd1);
        expect_pass();
        w0 = n_writes;
        pulse_tick();
        wait_idle();
        check(expq.size() == 0, "R1", "pending writes after pass", expq.size(), 0);
        check(n_writes - w0 == 6, "R1", "writes in pass", n_writes - w0, 6);
        check(touch25 == 0, "R3", "masked slot bus accesses", touch25, 0);
        check(mem[8'h25] == ref_mem[8'h25], "R3", "masked destination", mem[8'h25], ref_mem[8'h25]);
        check(!err_code, "R6", "err_code with valid codes", err_code, 0);

        // Pass 2: enable slot 6 with an unknown source code.
        cfg_write(2'd0, 6, mk(8'h05, 16'h0116, 8'h00, 16'h0126));
        cfg_write(2'd1, 0, 48'h8000_0000_005F);
        expect_pass();
        pulse_tick();
        wait_idle();
        check(err_code, "R6", "err_code after bad code", err_code, 1);
        check(touch26 == 0, "R6", "bad slot bus accesses", touch26, 0);
        check(expq.size() == 0, "R6", "other slots still ran", expq.size(), 0);

        // Period 0: ticks start nothing.
        cfg_write(2'd2, 0, 48'd0);
        r0 = n_req_cyc;
        repeat (5) pulse_tick();
        check(n_req_cyc == r0, "R4", "bus cycles with zero period", n_req_cyc - r0, 0);

        // Period 3: six ticks give passes on the first and fourth.
        cfg_write(2'd2, 0, 48'd3);
        expect_pass();
        expect_pass();
        w0 = n_writes;
        repeat (6) begin pulse_tick(); wait_idle(); end
        check(n_writes - w0 == 12, "R4", "writes over six ticks at period 3", n_writes - w0, 12);
        check(expq.size() == 0, "R4", "pending after period 3", expq.size(), 0);
        check(!err_overrun, "R7", "no overrun when spaced", err_overrun, 0);

        // Mid-pass reconfiguration applies only from the next pass.
        cfg_write(2'd2, 0, 48'd1);
        expect_pass();
        pulse_tick();
        cfg_write(2'd0, 0, mk(8'h01, 16'h0140, 8'h02, 16'h0141));
        cfg_write(2'd1, 0, 48'h0000_0000_0001);
        wait_idle();
        check(expq.size() == 0, "R8", "old config used in running pass", expq.size(), 0);
        expect_pass();
        w0 = n_writes;
        pulse_tick();
        wait_idle();
        check(expq.size() == 0, "R8", "new config in next pass", expq.size(), 0);
        check(n_writes - w0 == 1, "R8", "writes with new mask", n_writes - w0, 1);

        // Overrun: a second trigger during a pass is dropped.
        expect_pass();
        w0 = n_writes;
        pulse_tick();
        pulse_tick();
        wait_idle();
        check(err_overrun, "R7", "err_overrun after early trigger", err_overrun, 1);
        check(n_writes - w0 == 1, "R7", "dropped pass writes", n_writes - w0, 1);
        check(hold_viol == 0, "R10", "request hold violations", hold_viol, 0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule